// File: doc/BRIEF.md
# Bit-Slice 32-bit Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for a simple integer datapath. Two operand words and a three-bit operation code go in; a result word, a zero indication and a signed overflow indication come out in the same cycle. It is built as a ripple chain of one-bit slices. Each slice holds an AND gate, an OR gate, a full adder and a four-way result selector. The top slice also forms the overflow flag and the set-on-less-than signal.

Subtraction reuses the adder. The most significant bit of the operation code inverts operand B and forces the carry into the lowest slice. The signed less-than comparison takes the true sign of the difference, which is the adder's sign bit XOR overflow, and returns it into bit 0 of the result. The zero flag lets a datapath test two operands for equality by subtracting them.

The block has no clock and no state. Overflow is only reported; the block never acts on it.

Top module: `slice_alu32`

## Requirements
- R1: Operation code 000 returns the bitwise AND of A and B.
- R2: Operation code 001 returns the bitwise OR of A and B.
- R3: Operation code 010 returns A plus B modulo 2^32.
- R4: Operation code 110 returns A minus B modulo 2^32, formed as A plus the inverse of B plus one.
- R5: Operation code 111 returns 1 in bit 0 and zeros in bits 31..1 when A is less than B as signed two's complement values, and all zeros otherwise. This holds even when A minus B overflows.
- R6: The zero output is 1 exactly when all 32 result bits are 0.
- R7: On addition (010), overflow is 1 exactly when A and B have the same sign bit and bit 31 of the result differs from it. Operands of opposite sign never give overflow.
- R8: On subtraction (110), overflow is 1 exactly when A and B have different sign bits and bit 31 of the result differs from bit 31 of A. Operands of the same sign never give overflow.
- R9: Overflow is 0 for AND (000), OR (001) and set-on-less-than (111).
- R10: The unused codes 011, 100 and 101 return a result of all zeros, with overflow 0 and zero 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand (A) |
| opnd_b | input | 32 | Second operand (B) |
| op_code | input | 3 | Operation select; bit 2 inverts B and sets the carry-in |
| result | output | 32 | Operation result |
| zero_flag | output | 1 | 1 when the result is all zeros |
| ovf_flag | output | 1 | Signed overflow on add or subtract |

## Verification
The hardest case to reach is a set-on-less-than whose internal subtraction overflows. Here the raw sign bit gives the wrong answer, and only the sign XOR overflow gives the right one. Uniformly random operands seldom hit the overflow boundaries, so the random operand generator picks values near the most positive and most negative words much more often than other values. Directed vectors also pair the most negative value with small positives, and the most positive value with minus one. The same biased operands reach the overflow edges of addition and subtraction, and the zero result of equal operands.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;
    typedef enum logic [2:0] {
        OP_AND  = 3'b000,
        OP_OR   = 3'b001,
        OP_ADD  = 3'b010,
        OP_SUB  = 3'b110,
        OP_SLT  = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        PICK_AND  = 2'b00,
        PICK_OR   = 2'b01,
        PICK_SUM  = 2'b10,
        PICK_LESS = 2'b11
    } slice_pick_e;
endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import slice_alu_pkg::*;
(
    input  logic        a_bit,
    input  logic        b_bit,
    input  logic        b_invert,
    input  logic        carry_in,
    input  logic        less_in,
    input  slice_pick_e pick,
    output logic        res_bit,
    output logic        sum_bit,
    output logic        carry_out
);
    logic b_eff;

    always_comb begin
        b_eff     = b_bit ^ b_invert;
        sum_bit   = a_bit ^ b_eff ^ carry_in;
        carry_out = (a_bit & b_eff) | (a_bit & carry_in) | (b_eff & carry_in);
        unique case (pick)
            PICK_AND:  res_bit = a_bit & b_eff;
            PICK_OR:   res_bit = a_bit | b_eff;
            PICK_SUM:  res_bit = sum_bit;
            PICK_LESS: res_bit = less_in;
            default:   res_bit = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_top_slice.sv
module alu_top_slice
    import slice_alu_pkg::*;
(
    input  logic        a_bit,
    input  logic        b_bit,
    input  logic        b_invert,
    input  logic        carry_in,
    input  slice_pick_e pick,
    output logic        res_bit,
    output logic        set_out,
    output logic        ovf_out
);
    logic sum_raw;
    logic c_out;

    alu_bit_slice u_core (
        .a_bit    (a_bit),
        .b_bit    (b_bit),
        .b_invert (b_invert),
        .carry_in (carry_in),
        .less_in  (1'b0),
        .pick     (pick),
        .res_bit  (res_bit),
        .sum_bit  (sum_raw),
        .carry_out(c_out)
    );

    always_comb begin
        ovf_out = carry_in ^ c_out;
        set_out = sum_raw ^ ovf_out;
    end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] word,
    output logic             is_zero
);
    always_comb is_zero = ~|word;
endmodule

// File: rtl/slice_alu32.sv
module slice_alu32
    import slice_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [2:0]       op_code,
    output logic [WIDTH-1:0] result,
    output logic             zero_flag,
    output logic             ovf_flag
);
    localparam int MSB = WIDTH - 1;

    logic             op_known;
    logic             arith_op;
    logic             b_inv;
    slice_pick_e      pick;
    logic [WIDTH-1:0] slice_res;
    logic             set_sig;
    logic             ovf_raw;

    always_comb begin
        unique case (op_code)
            OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT: op_known = 1'b1;
            default:                               op_known = 1'b0;
        endcase
        arith_op = (op_code == OP_ADD) || (op_code == OP_SUB);
        b_inv    = op_code[2];
        pick     = slice_pick_e'(op_code[1:0]);
    end

    for (genvar i = 0; i < MSB; i++) begin : gen_slice
        logic c_out;
        logic s_unused;
        logic c_in;
        if (i == 0) begin : gen_first
            always_comb c_in = b_inv;
        end else begin : gen_rest
            always_comb c_in = gen_slice[i-1].c_out;
        end
        alu_bit_slice u_slice (
            .a_bit    (opnd_a[i]),
            .b_bit    (opnd_b[i]),
            .b_invert (b_inv),
            .carry_in (c_in),
            .less_in  ((i == 0) ? set_sig : 1'b0),
            .pick     (pick),
            .res_bit  (slice_res[i]),
            .sum_bit  (s_unused),
            .carry_out(c_out)
        );
    end

    alu_top_slice u_msb (
        .a_bit    (opnd_a[MSB]),
        .b_bit    (opnd_b[MSB]),
        .b_invert (b_inv),
        .carry_in (gen_slice[MSB-1].c_out),
        .pick     (pick),
        .res_bit  (slice_res[MSB]),
        .set_out  (set_sig),
        .ovf_out  (ovf_raw)
    );

    always_comb begin
        result   = op_known ? slice_res : '0;
        ovf_flag = arith_op & ovf_raw;
    end

    alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
        .word   (result),
        .is_zero(zero_flag)
    );

    always_comb begin
        if (op_code == OP_ADD && opnd_a[MSB] != opnd_b[MSB])
            assert_add_mixed_sign_R7: assert (!ovf_flag);
        if (op_code == OP_ADD && opnd_a[MSB] == opnd_b[MSB] && result[MSB] != opnd_a[MSB])
            assert_add_wrap_R7: assert (ovf_flag);
        if (op_code == OP_SUB && opnd_a[MSB] == opnd_b[MSB])
            assert_sub_same_sign_R8: assert (!ovf_flag);
        if (op_code == OP_SLT)
            assert_slt_upper_clear_R5: assert (result[MSB:1] == '0);
        if (op_code == OP_AND || op_code == OP_OR || op_code == OP_SLT)
            assert_no_overflow_R9: assert (!ovf_flag);
        if (!op_known)
            assert_unused_quiet_R10: assert (result == '0 && !ovf_flag && zero_flag);
        assert_zero_match_R6: assert (zero_flag == (result == '0));
    end
endmodule

// File: tb/test_slice_alu32.sv
module test_slice_alu32;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a, b;
    logic [2:0]  op;
    logic [31:0] res;
    logic        zf, of;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    slice_alu32 i_slice_alu32 (
        .opnd_a(a), .opnd_b(b), .op_code(op),
        .result(res), .zero_flag(zf), .ovf_flag(of)
    );

    function automatic logic [31:0] exp_res(input logic [31:0] x, input logic [31:0] y, input logic [2:0] o);
        case (o)
            3'b000:  return x & y;
            3'b001:  return x | y;
            3'b010:  return x + y;
            3'b110:  return x - y;
            3'b111:  return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic exp_ovf(input logic [31:0] x, input logic [31:0] y, input logic [2:0] o);
        logic [31:0] r;
        r = exp_res(x, y, o);
        if (o == 3'b010) return (x[31] == y[31]) && (r[31] != x[31]);
        if (o == 3'b110) return (x[31] != y[31]) && (r[31] != x[31]);
        return 1'b0;
    endfunction

    function automatic string res_tag(input logic [2:0] o);
        case (o)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b110:  return "R4";
            3'b111:  return "R5";
            default: return "R10";
        endcase
    endfunction

    function automatic string ovf_tag(input logic [2:0] o);
        case (o)
            3'b010:                 return "R7";
            3'b110:                 return "R8";
            3'b000, 3'b001, 3'b111: return "R9";
            default:                return "R10";
        endcase
    endfunction

    task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic [2:0] o);
        logic [31:0] er;
        logic        eo;
        @(negedge clk);
        a = x; b = y; op = o;
        #5;
        er = exp_res(x, y, o);
        eo = exp_ovf(x, y, o);
        n_cmp++;
        if (res !== er) begin
            n_bad++;
            $display("FAIL %s result a=%h b=%h op=%b actual=%h expected=%h", res_tag(o), x, y, o, res, er);
        end
        n_cmp++;
        if (zf !== (er == 32'd0)) begin
            n_bad++;
            $display("FAIL R6 zero a=%h b=%h op=%b actual=%b expected=%b", x, y, o, zf, (er == 32'd0));
        end
        n_cmp++;
        if (of !== eo) begin
            n_bad++;
            $display("FAIL %s overflow a=%h b=%h op=%b actual=%b expected=%b", ovf_tag(o), x, y, o, of, eo);
        end
    endtask

    function automatic logic [31:0] pick_operand();
        case ($urandom_range(0, 7))
            0: return 32'h7FFF_FFFF - $urandom_range(0, 3);
            1: return 32'h8000_0000 + $urandom_range(0, 3);
            2: return $urandom_range(0, 3);
            3: return 32'hFFFF_FFFF - $urandom_range(0, 3);
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        a = '0; b = '0; op = 3'b000;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // reset state: all-zero inputs, AND -> zero result, zero=1 (R1, R6)
        apply(32'h0, 32'h0, 3'b000);
        // directed corners
        apply(32'hF0F0_1234, 32'h0FF0_FFFF, 3'b000);         // R1
        apply(32'hF0F0_1234, 32'h0FF0_0000, 3'b001);         // R2
        apply(32'h7FFF_FFFF, 32'h0000_0001, 3'b010);         // R3 R7 wrap
        apply(32'h8000_0000, 32'h8000_0000, 3'b010);         // R7 neg wrap, R6
        apply(32'h7FFF_FFFF, 32'h8000_0000, 3'b010);         // R7 mixed signs
        apply(32'h8000_0000, 32'h0000_0001, 3'b110);         // R4 R8 overflow
        apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110);         // R8 overflow
        apply(32'h1234_5678, 32'h1234_5678, 3'b110);         // R6 equality
        apply(32'h8000_0000, 32'h0000_0001, 3'b111);         // R5 with overflow -> 1
        apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111);         // R5 with overflow -> 0
        apply(32'hFFFF_FFFF, 32'h0000_0000, 3'b111);         // R5 -1 < 0
        apply(32'h0000_0005, 32'h0000_0005, 3'b111);         // R5 equal -> 0
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011);         // R10
        apply(32'h7FFF_FFFF, 32'h0000_0001, 3'b100);         // R10
        apply(32'h8000_0000, 32'h8000_0000, 3'b101);         // R10
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b001);         // R9 OR no overflow
        // constrained random over all codes
        for (int k = 0; k < 4000; k++) begin
            apply(pick_operand(), pick_operand(), 3'($urandom_range(0, 7)));
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule